// File: doc/BRIEF.md
# Programmable Address Window Router

This block sits on the processor side of an I/O hub and decides which of four downstream bridge ports should receive a given address. Software programs four direct windows. Each window is described by three 64-bit registers: a start address, a size mask and a destination selector. The lookup path is purely combinational. It takes an address and reports whether any active window claims it, which window did, and which port that window targets.

The register side accepts 64-bit accesses and 32-bit accesses. A 32-bit access reaches one half of a 64-bit register, picked by address bit 2, and a 32-bit write leaves the other half untouched. Addresses outside the window register block are flagged as decode errors. Reads of such addresses return zero, and writes to them change nothing. Register updates are captured on the clock edge, so the lookup path sees them from the next cycle on.

Top module: `addr_window_router`

## Requirements
- R1: After reset every register reads as zero, every window is inactive, and any lookup misses.
- R2: Window n (n = 0..3) has its start register at byte offset 0x300 + 24n, its mask register at that offset + 8, and its selector register at that offset + 16. A 64-bit write followed by a 64-bit read at the same offset returns the written value.
- R3: A 32-bit write (reg_wide = 0) takes reg_wdata[31:0]. With reg_addr[2] = 1 it replaces bits 63:32 of the register, and with reg_addr[2] = 0 it replaces bits 31:0. The other half keeps its old value in both cases.
- R4: A 32-bit read returns bits 63:32 of the register in reg_rdata[31:0] when reg_addr[2] = 1, and bits 31:0 when reg_addr[2] = 0. In both cases reg_rdata[63:32] is zero.
- R5: An access to an address below 0x300 or at or above 0x360 raises reg_err in the same cycle, whether it is a read or a write. Such a read returns zero, and such a write alters no register.
- R6: A window is active only when bit 0 of its start register is 1 and its span is non-zero. The span is the two's complement of the mask, (~mask + 1), with bits 11:0 cleared.
- R7: An active window claims address A when B <= A < B + span, where B is the start register with bits 11:0 cleared. The comparison uses all 64 address bits.
- R8: The port reported for a claiming window is its selector register bits 1:0, which is the selector AND 3.
- R9: When several active windows claim an address, the lowest-numbered one is reported in lk_win and it sets lk_port.
- R10: When no active window claims the address, lk_miss = 1, lk_hit = 0 and lk_port = lk_win = 0. Otherwise lk_hit = 1 and lk_miss = 0.
- R11: A register write changes the lookup result only from the cycle after the write cycle. The lookup follows lk_addr within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational |
| reg_err | output | 1 | Decode error for the current access |
| lk_addr | input | 64 | Address to route |
| lk_hit | output | 1 | Some active window claims lk_addr |
| lk_miss | output | 1 | No active window claims lk_addr |
| lk_port | output | 2 | Selected downstream port |
| lk_win | output | 2 | Index of the claiming window |

## Verification
The windows are set up to overlap partly. Window 0 is a 64 KiB region that lies inside window 1, which is 1 MiB. Probes are placed just below, at, and just past each edge. Together these probes show whether the priority, the page alignment of the start, and the span arithmetic are right. Window 2 has a mask whose span is below one page, and window 3 is disabled. These two cases tell the non-zero-span condition apart from the enable-bit condition. A probe that differs only above bit 31 checks that the full 64-bit compare is used. The 32-bit writes carry garbage in their upper data bits and are done in both half orders, so a swapped half, or a merge that does not keep the other half, shows up when the register is read back at 64 bits.

// File: rtl/war_pkg.sv
package war_pkg;

  localparam int unsigned REG_W     = 64;
  localparam int unsigned PAGE_BITS = 12;

  typedef logic [REG_W-1:0] reg64_t;

  typedef struct packed {
    reg64_t start;
    reg64_t mask;
    reg64_t sel;
  } win_cfg_t;

  localparam int unsigned CFG_W = $bits(win_cfg_t);

  // clear the in-page bits of a value
  function automatic reg64_t page_floor(input reg64_t v);
    reg64_t r;
    r = v;
    r[PAGE_BITS-1:0] = '0;
    return r;
  endfunction

  // span of a window from its mask: two's complement, page aligned
  function automatic reg64_t win_span(input reg64_t mask);
    return page_floor(~mask + reg64_t'(1));
  endfunction

  // replace one 32-bit half of a register
  function automatic reg64_t merge_half(input reg64_t old, input logic [31:0] nw,
                                        input logic upper);
    return upper ? {nw, old[31:0]} : {old[63:32], nw};
  endfunction

  // fetch one 32-bit half of a register
  function automatic logic [31:0] pick_half(input reg64_t v, input logic upper);
    return upper ? v[63:32] : v[31:0];
  endfunction

endpackage

// File: rtl/war_regfile.sv
module war_regfile
  import war_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_OFF = 'h300
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic                        rd,
  input  logic                        wide,
  input  logic [ADDR_W-1:0]           addr,
  input  reg64_t                      wdata,
  output reg64_t                      rdata,
  output logic                        err,
  output logic                        wr_commit,
  output win_cfg_t [NUM_WIN-1:0]      cfg
);

  localparam int unsigned NREG  = 3 * NUM_WIN;
  localparam int unsigned IDX_W = ADDR_W - 3;

  reg64_t            store [NREG];
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic              mapped;
  logic              upper;
  reg64_t            sel_val;
  logic              unused_lo;

  assign rel       = addr - ADDR_W'(BASE_OFF);
  assign idx       = rel[ADDR_W-1:3];
  assign upper     = addr[2];
  assign mapped    = (addr >= ADDR_W'(BASE_OFF)) && (idx < IDX_W'(NREG));
  assign unused_lo = ^{rel[2:0], addr[1:0]};

  assign wr_commit = wr && mapped;

  // one storage element per register
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic hit_k;
    assign hit_k = wr_commit && (idx == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        store[k] <= '0;
      end else if (hit_k) begin
        if (wide) store[k] <= wdata;
        else      store[k] <= merge_half(store[k], wdata[31:0], upper);
      end
    end
  end

  // pack the triplets per window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_pack
    assign cfg[w].start = store[3*w];
    assign cfg[w].mask  = store[3*w+1];
    assign cfg[w].sel   = store[3*w+2];
  end

  // read mux
  always_comb begin
    sel_val = '0;
    for (int k = 0; k < NREG; k++) begin
      if (idx == IDX_W'(k)) sel_val = store[k];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && mapped) begin
      if (wide) rdata = sel_val;
      else      rdata = {32'h0, pick_half(sel_val, upper)};
    end
  end

  assign err = (rd || wr) && !mapped;

endmodule

// File: rtl/war_window.sv
module war_window
  import war_pkg::*;
#(
  parameter int unsigned PORT_W = 2
) (
  input  win_cfg_t           cfg,
  input  reg64_t             lk_addr,
  output logic               active,
  output logic               match,
  output logic [PORT_W-1:0]  port
);

  reg64_t start_al;
  reg64_t span;
  reg64_t offset;
  logic   unused_sel;

  assign start_al   = page_floor(cfg.start);
  assign span       = win_span(cfg.mask);
  assign offset     = lk_addr - start_al;

  assign active     = cfg.start[0] && (span != '0);
  assign match      = active && (lk_addr >= start_al) && (offset < span);
  assign port       = cfg.sel[PORT_W-1:0];
  assign unused_sel = ^cfg.sel[REG_W-1:PORT_W];

endmodule

// File: rtl/war_priority.sv
module war_priority #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned PORT_W  = 2,
  parameter int unsigned WIN_W   = 2
) (
  input  logic [NUM_WIN-1:0]             match,
  input  logic [NUM_WIN-1:0][PORT_W-1:0] ports,
  output logic                           hit,
  output logic [WIN_W-1:0]               win,
  output logic [PORT_W-1:0]              port
);

  // scan from the top down so the lowest claimer is left standing
  always_comb begin
    hit  = 1'b0;
    win  = '0;
    port = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        win  = WIN_W'(i);
        port = ports[i];
      end
    end
  end

endmodule

// File: rtl/addr_window_router.sv
module addr_window_router
  import war_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned NUM_PORT = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_OFF = 'h300
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic                            reg_wide,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [63:0]                     reg_wdata,
  output logic [63:0]                     reg_rdata,
  output logic                            reg_err,
  input  logic [63:0]                     lk_addr,
  output logic                            lk_hit,
  output logic                            lk_miss,
  output logic [$clog2(NUM_PORT)-1:0]     lk_port,
  output logic [$clog2(NUM_WIN)-1:0]      lk_win
);

  localparam int unsigned PORT_W = $clog2(NUM_PORT);
  localparam int unsigned WIN_W  = $clog2(NUM_WIN);

  win_cfg_t [NUM_WIN-1:0]             cfg;
  logic [NUM_WIN*CFG_W-1:0]           cfg_flat;
  logic [NUM_WIN-1:0]                 win_active;
  logic [NUM_WIN-1:0]                 win_match;
  logic [NUM_WIN-1:0][PORT_W-1:0]     win_port;
  logic                               wr_commit;

  war_regfile #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .BASE_OFF(BASE_OFF)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .wide     (reg_wide),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .err      (reg_err),
    .wr_commit(wr_commit),
    .cfg      (cfg)
  );

  assign cfg_flat = cfg;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    war_window #(.PORT_W(PORT_W)) u_win (
      .cfg    (cfg[w]),
      .lk_addr(lk_addr),
      .active (win_active[w]),
      .match  (win_match[w]),
      .port   (win_port[w])
    );
  end

  war_priority #(
    .NUM_WIN(NUM_WIN),
    .PORT_W (PORT_W),
    .WIN_W  (WIN_W)
  ) u_pick (
    .match(win_match),
    .ports(win_port),
    .hit  (lk_hit),
    .win  (lk_win),
    .port (lk_port)
  );

  assign lk_miss = !lk_hit;

endmodule

// File: rtl/war_checker.sv
module war_checker #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned WIN_W   = 2,
  parameter int unsigned PORT_W  = 2,
  parameter int unsigned CFG_W   = 192
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic                       reg_wide,
  input logic                       reg_err,
  input logic [63:0]                reg_rdata,
  input logic                       lk_hit,
  input logic                       lk_miss,
  input logic [PORT_W-1:0]          lk_port,
  input logic [WIN_W-1:0]           lk_win,
  input logic [NUM_WIN-1:0]         win_active,
  input logic [NUM_WIN-1:0]         win_match,
  input logic [NUM_WIN*CFG_W-1:0]   cfg_flat
);

  logic [NUM_WIN-1:0] below;
  assign below = (NUM_WIN'(1) << lk_win) - NUM_WIN'(1);

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit != lk_miss);                                                   // R10
  AST_MISS_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_port == '0 && lk_win == '0));                         // R10
  AST_GRANT_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> win_match[lk_win]);                                        // R7
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((win_match & below) == '0));                              // R9
  AST_IDLE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (win_match & ~win_active) == '0);                                     // R6
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wide) |-> (reg_rdata[63:32] == 32'h0));               // R4
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_err) |-> (reg_rdata == 64'h0));                        // R5
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_err) |=> $stable(cfg_flat));                           // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(cfg_flat));                                       // R11

endmodule

bind addr_window_router war_checker #(
  .NUM_WIN(NUM_WIN),
  .WIN_W  (WIN_W),
  .PORT_W (PORT_W),
  .CFG_W  (war_pkg::CFG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wide  (reg_wide),
  .reg_err   (reg_err),
  .reg_rdata (reg_rdata),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_port   (lk_port),
  .lk_win    (lk_win),
  .win_active(win_active),
  .win_match (win_match),
  .cfg_flat  (cfg_flat)
);

// File: tb/sim_addr_window_router.sv
module sim_addr_window_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wide = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_err;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic        lk_miss;
  logic [1:0]  lk_port;
  logic [1:0]  lk_win;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_window_router u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_port(lk_port), .lk_win(lk_win)
  );

  // bench-side register image
  logic [63:0] shadow [12];

  // scoreboard: 0 rdata, 1 err, 2 hit, 3 miss, 4 port, 5 win
  string       tag_q [$];
  int          fld_q [$];
  logic [63:0] exp_q [$];
  event        chk_ev;

  function automatic logic [63:0] observe(input int f);
    case (f)
      0: return reg_rdata;
      1: return {63'h0, reg_err};
      2: return {63'h0, lk_hit};
      3: return {63'h0, lk_miss};
      4: return {62'h0, lk_port};
      default: return {62'h0, lk_win};
    endcase
  endfunction

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        string       t;
        int          f;
        logic [63:0] e;
        logic [63:0] a;
        t = tag_q.pop_front();
        f = fld_q.pop_front();
        e = exp_q.pop_front();
        a = observe(f);
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s field %0d actual %h expected %h", t, f, a, e);
        end
      end
    end
  end

  task automatic push(input string t, input int f, input logic [63:0] e);
    tag_q.push_back(t);
    fld_q.push_back(f);
    exp_q.push_back(e);
  endtask

  task automatic fire();
    #1 -> chk_ev;
    #1;
  endtask

  function automatic int map_idx(input logic [15:0] a);
    if (a < 16'h300 || a >= 16'h360) return -1;
    return int'((a - 16'h300) >> 3);
  endfunction

  function automatic void shadow_wr(input logic [15:0] a, input logic [63:0] d,
                                    input bit wide);
    int k;
    k = map_idx(a);
    if (k < 0) return;
    if (wide)      shadow[k] = d;
    else if (a[2]) shadow[k][63:32] = d[31:0];
    else           shadow[k][31:0]  = d[31:0];
  endfunction

  // expected lookup from the stated window rules
  task automatic model_lookup(input logic [63:0] a, output bit hit,
                              output logic [1:0] port, output logic [1:0] win);
    hit = 0; port = 0; win = 0;
    for (int w = 0; w < 4; w++) begin
      logic [63:0] b;
      logic [63:0] s;
      b = shadow[3*w] & ~64'hFFF;
      s = (~shadow[3*w+1] + 64'd1) & ~64'hFFF;
      if (!hit && shadow[3*w][0] && s != 0 && a >= b && (a - b) < s) begin
        hit  = 1;
        port = shadow[3*w+2][1:0];
        win  = 2'(w);
      end
    end
  endtask

  task automatic push_lookup(input string t, input logic [63:0] a);
    bit         h;
    logic [1:0] p;
    logic [1:0] w;
    model_lookup(a, h, p, w);
    push(t, 2, {63'h0, h});
    push(t, 3, {63'h0, !h});
    push(t, 4, {62'h0, p});
    push(t, 5, {62'h0, w});
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wide = wide; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    shadow_wr(a, d, wide);
  endtask

  task automatic do_rd(input string t, input logic [15:0] a, input bit wide);
    int          k;
    logic [63:0] e;
    @(negedge clk);
    reg_addr = a; reg_wide = wide; reg_rd = 1'b1;
    k = map_idx(a);
    if (k < 0)     e = 64'h0;
    else if (wide) e = shadow[k];
    else           e = {32'h0, a[2] ? shadow[k][63:32] : shadow[k][31:0]};
    push(t, 0, e);
    push(t, 1, {63'h0, k < 0});
    fire();
    reg_rd = 1'b0;
  endtask

  task automatic do_look(input string t, input logic [63:0] a);
    @(negedge clk);
    lk_addr = a;
    push_lookup(t, a);
    fire();
  endtask

  initial begin
    for (int k = 0; k < 12; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_rd("R1 reset start0", 16'h300, 1);
    do_rd("R1 reset sel3", 16'h358, 1);
    do_look("R1 reset lookup", 64'h8000_1000);

    // R2 program windows at their offsets
    do_wr(16'h300, 64'h0000_0000_8000_1001, 1);
    do_wr(16'h308, 64'hFFFF_FFFF_FFFF_0000, 1);
    do_wr(16'h310, 64'h6, 1);
    do_wr(16'h318, 64'h8000_0001, 1);
    do_wr(16'h320, 64'hFFFF_FFFF_FFF0_0000, 1);
    do_wr(16'h328, 64'h1, 1);
    do_wr(16'h330, 64'hA000_0001, 1);
    do_wr(16'h338, 64'hFFFF_FFFF_FFFF_F800, 1);
    do_wr(16'h340, 64'h2, 1);
    do_wr(16'h348, 64'hDEAD_BEEF_9000_0000, 0);   // R3 low half, garbage above
    do_wr(16'h34C, 64'h1234_5678_0000_0000, 0);   // R3 high half gets zero
    do_wr(16'h350, 64'hFFFF_FFFF_F000_0000, 1);
    do_wr(16'h358, 64'h7, 1);
    do_rd("R2 start0 readback", 16'h300, 1);
    do_rd("R2 sel1 readback", 16'h328, 1);
    do_rd("R3 start3 merged", 16'h348, 1);

    // R4 narrow reads
    do_rd("R4 mask3 high half", 16'h354, 0);
    do_rd("R4 mask3 low half", 16'h350, 0);

    // R3 both half orders preserve the other half
    do_wr(16'h31C, 64'hCAFE_0000_0000_0012, 0);
    do_wr(16'h318, 64'hF00D_0000_8000_0001, 0);
    do_rd("R3 start1 both halves", 16'h318, 1);
    do_wr(16'h31C, 64'h0, 0);
    do_rd("R3 start1 high cleared", 16'h318, 1);

    // R7 R9 R10 edges of overlapping windows
    do_look("R9 overlap win0 start", 64'h8000_1000);
    do_look("R7 below win0 in win1", 64'h8000_0FFF);
    do_look("R7 win0 last byte", 64'h8001_0FFF);
    do_look("R7 past win0", 64'h8001_1000);
    do_look("R7 win1 first byte", 64'h8000_0000);
    do_look("R7 win1 last byte", 64'h800F_FFFF);
    do_look("R10 past win1", 64'h8010_0000);
    do_look("R10 below win1", 64'h7FFF_FFFF);
    do_look("R7 high address bits", 64'h1_8000_1000);
    do_look("R6 sub-page span inactive", 64'hA000_0000);
    do_look("R6 enable bit clear", 64'h9000_0000);

    // R11 write visible the next cycle only
    @(negedge clk);
    lk_addr = 64'h9000_0004;
    reg_addr = 16'h348; reg_wdata = 64'h9000_0001; reg_wide = 0; reg_wr = 1'b1;
    push_lookup("R11 same cycle unchanged", 64'h9000_0004);
    fire();
    @(negedge clk);
    reg_wr = 1'b0;
    shadow_wr(16'h348, 64'h9000_0001, 0);
    push_lookup("R11 next cycle win3", 64'h9000_0004);
    fire();
    do_look("R8 sel 7 to port 3", 64'h9FFF_FFFF);

    // R5 unmapped accesses
    do_rd("R5 read below block", 16'h2F8, 1);
    do_rd("R5 read past block", 16'h360, 1);
    do_rd("R5 narrow read far", 16'h1304, 0);
    @(negedge clk);
    reg_addr = 16'h360; reg_wdata = '1; reg_wide = 1; reg_wr = 1'b1;
    push("R5 write err", 1, 64'h1);
    fire();
    @(negedge clk);
    reg_wr = 1'b0;
    do_rd("R5 start0 untouched", 16'h300, 1);
    do_rd("R5 sel3 untouched", 16'h358, 1);
    do_look("R5 lookup unchanged", 64'h8000_1000);

    // R8 selector upper bits ignored
    do_wr(16'h310, 64'hFFFF_FFFF_FFFF_FFFC, 1);
    do_look("R8 sel masked to port 0", 64'h8000_2000);

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule